// File: doc/BRIEF.md
# Manchester Transmit Encoder

This block turns a serial NRZ bit stream into Manchester line code for a 10 Mb/s transmitter. It runs from a clock at twice the bit rate and emits one half-bit per clock on a single-ended line output. A bit-strobe input pulses once every two clocks and marks the clock in which the NRZ data bit and the transmit-enable input are sampled.

A frame starts when transmit-enable is seen high on a strobe while the link-good input is high. It continues bit after bit until a strobe finds transmit-enable low. The frame then stops on a bit-cell boundary, and the bit offered on that strobe is never sent. The line rests high between frames, and an idle flag marks those stretches. After a final 1 the last line edge is therefore the one at mid-cell. After a final 0 the line steps back up at the cell boundary.

If the link drops during a frame, the frame is cut off on the next clock. No new frame can start until transmit-enable has been seen low. While the link is down and no frame is active, transmit-enable has no effect.

Top module: `manch_tx_enc`

## Requirements
- R1: After a clock with rst_n low, line_o is 1 and idle_o is 1.
- R2: From idle, a clock edge with bit_stb, tx_en and link_ok all high starts a frame. On that same edge idle_o goes to 0 and line_o takes the first half of the bit on nrz_i.
- R3: Each bit spans two clocks. A 1 is sent as line_o = 0 then 1, and a 0 as line_o = 1 then 0. The first half appears on the strobe edge that samples the bit and the second half on the following edge.
- R4: While tx_en and link_ok stay high, each strobe edge starts the next bit at once, with no gap between bits.
- R5: During a frame, a strobe edge with tx_en low ends the frame. On that edge line_o goes to 1 and idle_o to 1, and the bit on nrz_i at that strobe is not sent.
- R6: When the final bit is 1, the line shows no edge after that bit's mid-cell edge: line_o stays 1 through the end of the frame.
- R7: When the final bit is 0, line_o rises from 0 to 1 on the edge at the bit-cell boundary where the frame ends.
- R8: A clock edge during a frame with link_ok low ends the frame at once: line_o goes to 1 and idle_o to 1 on that edge.
- R9: After a frame is cut off by the link with tx_en still high, no frame starts until tx_en has been sampled low on some edge.
- R10: While idle with link_ok low, tx_en and bit_stb have no effect: line_o stays 1 and idle_o stays 1.
- R11: Between frames, line_o and idle_o hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| link_ok | input | 1 | Link-good indication; transmission allowed only while high |
| tx_en | input | 1 | Transmit enable, sampled on strobe clocks |
| bit_stb | input | 1 | Bit strobe, high for one clock out of every two |
| nrz_i | input | 1 | NRZ data bit, sampled on strobe clocks |
| line_o | output | 1 | Manchester line output, one half-bit per clock |
| idle_o | output | 1 | High while no frame is being sent |

## Verification
On every clock, the assertions check the following. The second half of each bit inverts the first. Ending or cutting off a frame leaves the line high with idle set. The line is high whenever idle is set. A dropped link keeps an idle encoder idle. A locked-out encoder stays locked until transmit-enable falls. Only the bench scenarios can show the order of half-bits against each bit value, which cell position carries the last edge for each final bit, whether the bit offered at the ending strobe is left out, and restarting after a lockout.

// File: rtl/manch_tx_pkg.sv
// Package: shared state encoding for the Manchester transmit encoder.
// Assumes: included ahead of every module that uses the state type.
package manch_tx_pkg;

    // Frame control states; the name says what the line shows after the edge.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_LOCK   = 2'd3
    } mtx_state_e;

endpackage

// File: rtl/manch_frame_ctl.sv
// Module: frame control for the Manchester encoder. It decides on each edge
// whether a new bit is loaded, the second half is driven, or the line is
// returned to rest.
// Assumes: bit_stb is high for one clock out of every two; tx_en and nrz
// are only meaningful on strobe clocks.
module manch_frame_ctl
    import manch_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic tx_en,
    input  logic bit_stb,
    output logic load_o,
    output logic second_o,
    output logic quiet_o
);

    mtx_state_e state_q;
    mtx_state_e state_d;

    // Next-state and action decode.
    always_comb begin
        state_d  = state_q;
        load_o   = 1'b0;
        second_o = 1'b0;
        quiet_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_stb && tx_en && link_ok) begin
                    load_o  = 1'b1;
                    state_d = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (!link_ok) begin
                    quiet_o = 1'b1;
                    state_d = tx_en ? ST_LOCK : ST_IDLE;
                end else begin
                    second_o = 1'b1;
                    state_d  = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (!link_ok) begin
                    quiet_o = 1'b1;
                    state_d = tx_en ? ST_LOCK : ST_IDLE;
                end else if (bit_stb) begin
                    if (tx_en) begin
                        load_o  = 1'b1;
                        state_d = ST_FIRST;
                    end else begin
                        quiet_o = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_LOCK: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R10: a dropped link keeps an idle encoder idle.
    a_r10_link_down_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !link_ok) |=> (state_q == ST_IDLE));

    // R9: the lockout holds while tx_en stays high.
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && tx_en) |=> (state_q == ST_LOCK));

    // R8: a link drop during a frame leaves the active states.
    a_r8_link_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FIRST || state_q == ST_SECOND) && !link_ok)
        |=> (state_q == ST_IDLE || state_q == ST_LOCK));

endmodule

// File: rtl/manch_bit_hold.sv
// Module: holds the current NRZ bit so its second half can be driven.
// Assumes: load_i is high only on strobe edges that start a bit.
module manch_bit_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic nrz_i,
    output logic bit_o
);

    // Capture the sampled data bit on load.
    always_ff @(posedge clk) begin
        if (!rst_n)      bit_o <= 1'b0;
        else if (load_i) bit_o <= nrz_i;
    end

endmodule

// File: rtl/manch_line_drv.sv
// Module: line output register. It drives each half-cell level and the rest
// level, and keeps the idle flag.
// Assumes: second_i only follows a load by one clock; quiet_i marks the end
// of a frame.
module manch_line_drv #(
    parameter bit ONE_RISES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic second_i,
    input  logic quiet_i,
    input  logic nrz_i,
    input  logic held_i,
    output logic line_o,
    output logic idle_o
);

    localparam logic REST_LEVEL = ONE_RISES;

    logic first_lvl;
    logic second_lvl;

    // Polarity variant: chooses which half of a 1 is high.
    generate
        if (ONE_RISES) begin : g_rise
            assign first_lvl  = ~nrz_i;
            assign second_lvl = held_i;
        end else begin : g_fall
            assign first_lvl  = nrz_i;
            assign second_lvl = ~held_i;
        end
    endgenerate

    // Line register: a half-bit per clock, or the rest level at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)        line_o <= REST_LEVEL;
        else if (load_i)   line_o <= first_lvl;
        else if (second_i) line_o <= second_lvl;
        else if (quiet_i)  line_o <= REST_LEVEL;
    end

    // Idle flag: cleared when a frame starts, set when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       idle_o <= 1'b1;
        else if (load_i)  idle_o <= 1'b0;
        else if (quiet_i) idle_o <= 1'b1;
    end

    // R3: the second half of a cell is the inverse of the first.
    a_r3_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
        second_i |=> (line_o != $past(line_o)));

    // R5: ending a frame leaves the line at rest with idle set.
    a_r5_end_rest: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_i |=> (idle_o && line_o == REST_LEVEL));

    // R1: whenever idle, the line sits at the rest level.
    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (line_o == REST_LEVEL));

    // R11: between frames the outputs do not move.
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !load_i) |=> ($stable(line_o) && idle_o));

endmodule

// File: rtl/manch_tx_enc.sv
// Module: top of the Manchester transmit encoder. It ties frame control,
// bit hold and line driver together.
// Assumes: clock at twice the bit rate; bit_stb high every other clock.
module manch_tx_enc #(
    parameter bit ONE_RISES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic tx_en,
    input  logic bit_stb,
    input  logic nrz_i,
    output logic line_o,
    output logic idle_o
);

    logic load;
    logic second;
    logic quiet;
    logic held;

    manch_frame_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_ok  (link_ok),
        .tx_en    (tx_en),
        .bit_stb  (bit_stb),
        .load_o   (load),
        .second_o (second),
        .quiet_o  (quiet)
    );

    manch_bit_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .nrz_i  (nrz_i),
        .bit_o  (held)
    );

    manch_line_drv #(.ONE_RISES(ONE_RISES)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .second_i (second),
        .quiet_i  (quiet),
        .nrz_i    (nrz_i),
        .held_i   (held),
        .line_o   (line_o),
        .idle_o   (idle_o)
    );

endmodule

// File: tb/sim_manch_tx_enc.sv
// Bench: scoreboard for the Manchester transmit encoder. A driver task sets
// inputs at the falling edge and queues the expected outputs; a monitor
// checks them just after the following rising edge.
module sim_manch_tx_enc;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_ok = 1'b0;
    logic tx_en = 1'b0;
    logic bit_stb = 1'b0;
    logic nrz_i = 1'b0;
    logic line_o;
    logic idle_o;

    int n_run = 0;
    int n_fail = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    manch_tx_enc u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_ok (link_ok),
        .tx_en   (tx_en),
        .bit_stb (bit_stb),
        .nrz_i   (nrz_i),
        .line_o  (line_o),
        .idle_o  (idle_o)
    );

    // Driver: one clock of stimulus plus the expected line and idle.
    task automatic cyc(input logic tx, input logic lk, input logic stb,
                       input logic d, input logic e_line, input logic e_idle,
                       input string tag);
        @(negedge clk);
        tx_en = tx; link_ok = lk; bit_stb = stb; nrz_i = d;
        exp_q.push_back({e_line, e_idle});
        tag_q.push_back(tag);
    endtask

    // A full frame, first bit at index 0, then the ending strobe.
    task automatic send_frame(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b1, 1'b1, bits[i], ~bits[i], 1'b0, "R2 R3 R4");
            cyc(1'b1, 1'b1, 1'b0, 1'b0, bits[i], 1'b0, "R3");
        end
        // The bit offered at the ending strobe is 1: if sent, the line would go low.
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
            bits[n-1] ? "R5 R6" : "R5 R7");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
    endtask

    // Monitor: compares outputs just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if ({line_o, idle_o} !== e) begin
                n_fail++;
                $display("FAIL %s: line/idle actual %b%b expected %b%b",
                         t, line_o, idle_o, e[1], e[0]);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (line_o !== 1'b1 || idle_o !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: line/idle actual %b%b expected 11", line_o, idle_o);
        end
        rst_n = 1'b1;
        // R1 / R11: quiet after reset.
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R1");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R11");
        // Frame ending in 1 (R6), then one ending in 0 (R7).
        send_frame(16'h000D, 4);
        send_frame(16'h0006, 4);
        // R8: link drops while the first half is on the line; lockout follows (R9).
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        send_frame(16'h0002, 2);
        // R8: link drops on a strobe while the second half of a 0 is low.
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        // R10: tx_en and strobes with the link down do nothing.
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 1'b1, i[0], 1'b1, 1'b1, "R10");
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        end
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        // R4: a longer frame, back to back bits.
        send_frame(16'h0A5C, 12);
        send_frame(16'h0001, 1);
        send_frame(16'h0000, 1);
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule